// File: doc/BRIEF.md
# Moving Inversions Memory Self-Test Engine

This block runs a moving-inversions self-test on a single-port, word-wide RAM that has `ADDR_W` address bits and `DATA_W` data bits. A pulse on `start` makes it take over the RAM port. It first clears every word. It then performs `ADDR_W` repetitions, and each repetition has two phases. The up phase walks the words and turns on their bits one at a time. The down phase walks the words in the opposite order and turns the bits off again one at a time. The engine reads the word before the first change and after every change, and it compares each read against the value it expects.

The order in which addresses are visited changes from one repetition to the next. A logical counter steps through every value, and on repetition `k` the physical address is that counter rotated left by `k` bits. This means address bit `k` acts as the least significant bit. A carry out of the top bit wraps around into the bottom bit, so the visit order moves through strides of 1, 2, 4 and so on, and still reaches every word. The first mismatch is latched on the fail outputs together with its address and bit index. `done` rises when the last check has been made.

The RAM port is plain control and has no back-pressure. The engine issues at most one access per cycle. It expects read data one cycle after a cycle in which `mem_re` is high. A write in one cycle is visible to a read in the next cycle.

Top module: `mi_bist_engine`

## Requirements
- R1: During and right after reset, `done`, `fail`, `mem_we` and `mem_re` are low, and `fail_addr` and `fail_bit` are zero.
- R2: When `start` is sampled high in the idle or done state, the engine writes the all-zero word to address 0, 1, 2, … up to the top address, one write per cycle, and goes straight on into the up phase of repetition 0.
- R3: In the up phase, for each word the engine reads the word and expects 0. Then, for i = 0 to DATA_W-1, it writes a word whose bits 0..i are 1 and the others 0, and reads it back, expecting that same word. Each access takes one cycle, and `mem_we` and `mem_re` are never high together.
- R4: The down phase visits the words in reverse logical order. For each word it reads and expects all ones. Then, for i = 0 to DATA_W-1, it writes a word whose bits 0..i are 0 and the others 1, and reads it back, expecting that same word.
- R5: On repetition k (0-based), the address for logical count c is c rotated left by k within ADDR_W bits. With ADDR_W=4 and k=1, the 8th word of the up phase is 14, the 9th word is 1, and the second word of repetition 3 is 8.
- R6: The engine runs exactly ADDR_W repetitions. When the last read is issued in cycle t, `done` is high from cycle t+2 onward. While `done` is high the engine makes no RAM access, and `done` stays high until the next `start`.
- R7: `mem_rdata` is compared with the expected word in the cycle after the read. A mismatch sets `fail`.
- R8: `fail` is sticky. `fail_addr` and `fail_bit` keep the values from the first mismatch and are not changed by later mismatches. A `start` that is accepted clears all three.
- R9: `fail_bit` is the lowest bit index at which the read word differs from the expected word.
- R10: A `start` pulse that arrives while a test is running is ignored, and the access sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a test run when idle or done |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, one cycle after mem_re |
| done | output | 1 | Test complete |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_bit | output | BIT_W | Lowest differing bit of the first mismatch |

## Verification
The bench builds the engine with ADDR_W=4 and DATA_W=4, which gives 1168 accesses per run. With four repetitions, every rotation amount from 0 to 3 is used, including the one in which the carry wraps from the top bit into bit 0 after 1110. Four-bit words leave room for faults that hit two bits, so the lowest-index rule can be tested. A behavioural RAM in the bench can force bits to 1 or to 0 at two addresses that are visited at different times. This lets the bench test whether the fail report holds the first mismatch or a later one.

// File: rtl/mi_bist_pkg.sv
package mi_bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_UP, ST_DOWN, ST_DRAIN, ST_DONE
  } mi_state_t;
endpackage

// File: rtl/mi_addr_gen.sv
module mi_addr_gen #(
  parameter int ADDR_W = 4,
  parameter int REP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic              inc,
  input  logic              dec,
  input  logic              rep_clr,
  input  logic              rep_inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_hi,
  output logic              at_lo,
  output logic              rep_last
);
  logic [ADDR_W-1:0]   cnt;
  logic [REP_W-1:0]    rep;
  logic [2*ADDR_W-1:0] dbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rep <= '0;
    end else begin
      if (load_lo)      cnt <= '0;
      else if (load_hi) cnt <= '1;
      else if (inc)     cnt <= cnt + 1'b1;
      else if (dec)     cnt <= cnt - 1'b1;
      if (rep_clr)      rep <= '0;
      else if (rep_inc) rep <= rep + 1'b1;
    end
  end

  // rotate left by the repetition index: bit rep acts as the LSB, carry wraps
  always_comb begin
    dbl  = {cnt, cnt} << rep;
    addr = dbl[2*ADDR_W-1:ADDR_W];
  end

  assign at_hi    = (cnt == '1);
  assign at_lo    = (cnt == '0);
  assign rep_last = (int'(rep) == ADDR_W - 1);

  assert_rep_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rep) < ADDR_W);
  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_lo && !load_hi && !rep_inc) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/mi_word_seq.sv
module mi_word_seq #(
  parameter int DATA_W = 4,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] flips,
  output logic             is_wr,
  output logic             word_end
);
  assign word_end = !is_wr && (int'(flips) == DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flips <= '0;
      is_wr <= 1'b0;
    end else if (clr) begin
      flips <= '0;
      is_wr <= 1'b0;
    end else if (adv) begin
      if (is_wr) begin
        is_wr <= 1'b0;
        flips <= flips + 1'b1;
      end else if (word_end) begin
        flips <= '0;
      end else begin
        is_wr <= 1'b1;
      end
    end
  end

  assert_flip_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(flips) <= DATA_W);
  assert_read_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && adv && !clr) |=> !is_wr);
endmodule

// File: rtl/mi_resp_check.sv
module mi_resp_check #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter int BIT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [DATA_W-1:0] rd_data,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [BIT_W-1:0]  fail_bit
);
  logic              pend;
  logic [DATA_W-1:0] exp_q, diff;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  low;
  logic              mism;

  assign diff = rd_data ^ exp_q;
  assign mism = pend && (diff != '0);

  always_comb begin
    low = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (diff[i]) low = BIT_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      exp_q     <= '0;
      addr_q    <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_bit  <= '0;
    end else begin
      pend   <= rd_en;
      exp_q  <= rd_exp;
      addr_q <= rd_addr;
      if (clr) begin
        fail      <= 1'b0;
        fail_addr <= '0;
        fail_bit  <= '0;
      end else if (mism && !fail) begin
        fail      <= 1'b1;
        fail_addr <= addr_q;
        fail_bit  <= low;
      end
    end
  end

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail);
  assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> ($stable(fail_addr) && $stable(fail_bit)));
  assert_mismatch_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mism && !clr) |=> fail);
endmodule

// File: rtl/mi_bist_engine.sv
module mi_bist_engine
  import mi_bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int REP_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [BIT_W-1:0]  fail_bit
);
  mi_state_t state, nxt;

  logic load_lo, load_hi, inc, dec, rep_clr, rep_inc;
  logic at_hi, at_lo, rep_last;
  logic ws_clr, ws_adv, is_wr, word_end, chk_clr;
  logic [CNT_W-1:0]  flips;
  logic [DATA_W-1:0] exp_word;

  function automatic logic [DATA_W-1:0] low_ones(input int n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction

  mi_addr_gen #(.ADDR_W(ADDR_W), .REP_W(REP_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .load_hi(load_hi),
    .inc(inc), .dec(dec), .rep_clr(rep_clr), .rep_inc(rep_inc),
    .addr(mem_addr), .at_hi(at_hi), .at_lo(at_lo), .rep_last(rep_last)
  );

  mi_word_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_word (
    .clk(clk), .rst_n(rst_n), .clr(ws_clr), .adv(ws_adv),
    .flips(flips), .is_wr(is_wr), .word_end(word_end)
  );

  mi_resp_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(chk_clr), .rd_en(mem_re),
    .rd_addr(mem_addr), .rd_exp(exp_word), .rd_data(mem_rdata),
    .fail(fail), .fail_addr(fail_addr), .fail_bit(fail_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt       = state;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    exp_word  = '0;
    load_lo   = 1'b0;
    load_hi   = 1'b0;
    inc       = 1'b0;
    dec       = 1'b0;
    rep_clr   = 1'b0;
    rep_inc   = 1'b0;
    ws_clr    = 1'b0;
    ws_adv    = 1'b0;
    chk_clr   = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          nxt     = ST_FILL;
          load_lo = 1'b1;
          rep_clr = 1'b1;
          ws_clr  = 1'b1;
          chk_clr = 1'b1;
        end
      end
      ST_FILL: begin
        mem_we = 1'b1;
        if (at_hi) begin
          nxt     = ST_UP;
          load_lo = 1'b1;
        end else begin
          inc = 1'b1;
        end
      end
      ST_UP: begin
        ws_adv = 1'b1;
        if (is_wr) begin
          mem_we    = 1'b1;
          mem_wdata = low_ones(int'(flips) + 1);
        end else begin
          mem_re   = 1'b1;
          exp_word = low_ones(int'(flips));
        end
        if (word_end) begin
          if (at_hi) begin
            nxt     = ST_DOWN;
            load_hi = 1'b1;
          end else begin
            inc = 1'b1;
          end
        end
      end
      ST_DOWN: begin
        ws_adv = 1'b1;
        if (is_wr) begin
          mem_we    = 1'b1;
          mem_wdata = ~low_ones(int'(flips) + 1);
        end else begin
          mem_re   = 1'b1;
          exp_word = ~low_ones(int'(flips));
        end
        if (word_end) begin
          if (at_lo) begin
            if (rep_last) begin
              nxt = ST_DRAIN;
            end else begin
              nxt     = ST_UP;
              rep_inc = 1'b1;
              load_lo = 1'b1;
            end
          end else begin
            dec = 1'b1;
          end
        end
      end
      ST_DRAIN: nxt = ST_DONE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

  assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_we && !mem_re));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UP || state == ST_DOWN) |=> (state != ST_FILL));
  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/mi_bist_engine_test.sv
module mi_bist_engine_test;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int BW = 2;
  localparam int NW = 1 << AW;
  localparam int T  = NW + AW * 2 * NW * (2 * DW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_we, mem_re, done, fail;
  logic [BW-1:0] fail_bit;

  int total = 0, bad = 0;

  logic [DW-1:0] ram [NW];
  logic [AW-1:0] fa0, fa1;
  logic [DW-1:0] f_or, f_and;

  int e_we[T], e_re[T], e_addr[T], e_wd[T], e_ph[T];
  int o_addr[T + 2];

  always #10 clk = ~clk;

  mi_bist_engine #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_bit(fail_bit)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) begin
      mem_rdata <= ((mem_addr == fa0) ? (ram[mem_addr] | f_or) : ram[mem_addr])
                 & ((mem_addr == fa1) ? f_and : '1);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rotl(input int c, input int k);
    return ((c << k) | (c >> (AW - k))) & (NW - 1);
  endfunction

  function automatic int ones_lo(input int n);
    return (1 << n) - 1;
  endfunction

  task automatic build_expected();
    int p = 0;
    for (int c = 0; c < NW; c++) begin
      e_we[p] = 1; e_re[p] = 0; e_addr[p] = c; e_wd[p] = 0; e_ph[p] = 0; p++;
    end
    for (int k = 0; k < AW; k++) begin
      for (int c = 0; c < NW; c++) begin
        e_we[p] = 0; e_re[p] = 1; e_addr[p] = rotl(c, k); e_wd[p] = 0; e_ph[p] = 1; p++;
        for (int f = 1; f <= DW; f++) begin
          e_we[p] = 1; e_re[p] = 0; e_addr[p] = rotl(c, k); e_wd[p] = ones_lo(f); e_ph[p] = 1; p++;
          e_we[p] = 0; e_re[p] = 1; e_addr[p] = rotl(c, k); e_wd[p] = 0; e_ph[p] = 1; p++;
        end
      end
      for (int c = NW - 1; c >= 0; c--) begin
        e_we[p] = 0; e_re[p] = 1; e_addr[p] = rotl(c, k); e_wd[p] = 0; e_ph[p] = 2; p++;
        for (int f = 1; f <= DW; f++) begin
          e_we[p] = 1; e_re[p] = 0; e_addr[p] = rotl(c, k);
          e_wd[p] = (~ones_lo(f)) & ones_lo(DW); e_ph[p] = 2; p++;
          e_we[p] = 0; e_re[p] = 1; e_addr[p] = rotl(c, k); e_wd[p] = 0; e_ph[p] = 2; p++;
        end
      end
    end
  endtask

  task automatic clear_faults();
    fa0 = '0; fa1 = '0; f_or = '0; f_and = '1;
  endtask

  task automatic run_to_done(output int cycles);
    @(negedge clk); start = 1'b1;
    cycles = 0;
    do begin
      @(negedge clk); start = 1'b0; cycles++;
    end while (!done && cycles < 5000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!done && !fail && !mem_we && !mem_re, "R1 outputs quiet in reset",
          {done, fail, mem_we, mem_re}, 0);
    check(fail_addr == 0 && fail_bit == 0, "R1 fail fields zero", {fail_addr, fail_bit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_we && !mem_re, "R1 idle after reset", {done, mem_we, mem_re}, 0);
  endtask

  task automatic t_clean_run();
    int mis[3] = '{0, 0, 0};
    int first_bad[3] = '{-1, -1, -1};
    int late = 0;
    int d_t, d_t1, q_t, f_end;
    clear_faults();
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < T + 2; i++) begin
      @(negedge clk);
      start = (i == 100);
      o_addr[i] = mem_addr;
      if (i < T) begin
        bit ok = (mem_we == e_we[i][0]) && (mem_re == e_re[i][0]) &&
                 (int'(mem_addr) == e_addr[i]) &&
                 (!mem_we || int'(mem_wdata) == e_wd[i]);
        if (!ok) begin
          mis[e_ph[i]]++;
          if (first_bad[e_ph[i]] < 0) first_bad[e_ph[i]] = i;
          if (i > 100) late++;
        end
      end
      if (i == T)     begin d_t = done; q_t = mem_we | mem_re; end
      if (i == T + 1) begin d_t1 = done; f_end = fail; end
    end
    check(mis[0] == 0, "R2 zero fill sequence", first_bad[0], -1);
    check(mis[1] == 0, "R3 up phase accesses", first_bad[1], -1);
    check(mis[2] == 0, "R4 down phase accesses", first_bad[2], -1);
    check(o_addr[NW + NW*2*(2*DW+1) + 7*(2*DW+1)] == 14, "R5 rep1 word7 addr",
          o_addr[NW + NW*2*(2*DW+1) + 7*(2*DW+1)], 14);
    check(o_addr[NW + NW*2*(2*DW+1) + 8*(2*DW+1)] == 1, "R5 rep1 wraps to addr 1",
          o_addr[NW + NW*2*(2*DW+1) + 8*(2*DW+1)], 1);
    check(o_addr[NW + 3*NW*2*(2*DW+1) + (2*DW+1)] == 8, "R5 rep3 word1 addr",
          o_addr[NW + 3*NW*2*(2*DW+1) + (2*DW+1)], 8);
    check(late == 0, "R10 start mid-run ignored", late, 0);
    check(d_t == 0 && q_t == 0, "R6 done low in drain cycle", d_t, 0);
    check(d_t1 == 1, "R6 done two cycles after last read", d_t1, 1);
    check(f_end == 0, "R7 no fail on good RAM", f_end, 0);
    repeat (3) @(negedge clk);
    check(done && !mem_we && !mem_re, "R6 done held with no access", done, 1);
  endtask

  task automatic t_stuck_low();
    int cyc;
    clear_faults();
    fa1 = 4'd9; f_and = 4'b1110;
    run_to_done(cyc);
    check(fail == 1, "R7 stuck-at-0 detected", fail, 1);
    check(fail_addr == 9, "R7 stuck-at-0 address", fail_addr, 9);
    check(fail_bit == 0, "R7 stuck-at-0 bit", fail_bit, 0);
  endtask

  task automatic t_first_kept();
    int cyc;
    clear_faults();
    fa0 = 4'd6;  f_or  = 4'b1010;
    fa1 = 4'd12; f_and = 4'b1011;
    run_to_done(cyc);
    check(done == 1, "R6 done despite faults", done, 1);
    check(fail_addr == 6, "R8 first mismatch address kept", fail_addr, 6);
    check(fail_bit == 1, "R9 lowest differing bit", fail_bit, 1);
  endtask

  task automatic t_restart_clears();
    int cyc;
    clear_faults();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(fail == 0 && fail_addr == 0, "R8 start clears fail", fail, 0);
    do begin @(negedge clk); cyc++; end while (!done && cyc < 5000);
    check(done && !fail, "R8 clean rerun stays clear", fail, 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_faults();
    build_expected();
    repeat (2) @(negedge clk);
    t_reset();
    t_clean_run();
    t_stuck_low();
    t_first_kept();
    t_restart_clears();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule